// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This controller turns single-word read and write requests from the chip into cycles on an external asynchronous bus. The bus reaches three regions: a boot PROM, four SRAM banks and a memory-mapped I/O area. The region is chosen from the top address nibble. The block drives the address pins, drives and samples the data and check-bit lanes, and produces per-region chip selects, SRAM output enables, byte write strobes and the I/O handshake.

A request is accepted while `req_ready_o` is high. PROM and SRAM cycles last a programmed number of wait states plus one cycle. An I/O cycle runs until the ready input is seen asserted, and then lasts one more cycle. Completion is signalled by a one-cycle done pulse, with the read data and the sampled check bits held alongside it. The PROM and the I/O area may each be set to 8-bit width, in which case only the top byte lane is used. Error-correction codes are computed outside the block, and the block only carries them to and from the pins.

Top module: `ext_mem_ctrl`

## Requirements
- R1: Address nibble [31:28] values 0 and 1 select the PROM, 2 selects the I/O area and 4 selects the SRAM. Any other value raises `req_err_o` for exactly one cycle, in the cycle after acceptance. No select or strobe is asserted and the address pins do not change.
- R2: `rom_cs_no[0]` goes low for nibble 0 and `rom_cs_no[1]` goes low for nibble 1. The other PROM select stays high.
- R3: An SRAM access drives low only `ram_cs_no[b]`, where b is address bits [21:20]. On reads, `ram_oe_no[b]` also goes low. On writes, all output enables stay high.
- R4: A PROM or SRAM access keeps its selects asserted for exactly ws+1 cycles. ws is the PROM or SRAM wait-state field, sampled at acceptance. The done pulse appears in the cycle after the last bus cycle.
- R5: An I/O access drives `io_cs_no` low. A read also drives `io_oe_no` low and `io_rd_o` high. A write drives `io_we_no` low. The access ends on the rising edge that follows the edge at which `io_rdy_ni` was sampled low.
- R6: `mem_d_oe_o` is high only during write cycles. A 32-bit PROM or SRAM write drives all four strobes of `mem_we_no` low. The request data appears on `mem_d_o` unchanged.
- R7: In an 8-bit region, a write places request bits [7:0] on bus bits [31:24] and zeros on the other lanes. A PROM write asserts only strobe 0 (`mem_we_no[0]`). A read returns bus bits [31:24] zero-extended in `req_rdata_o[7:0]`.
- R8: `mem_cb_oe_o` is high only during writes to a protected 32-bit PROM or SRAM region. It then drives {test bit, code[6:0]}. After a read, `req_rcb_o` holds the check-bit pins as sampled at the last bus edge.
- R9: `mem_a_o` carries request address bits [22:0] from the first bus cycle onward. It keeps that value until the next accepted access to a valid region.
- R10: After a read, one cycle follows with every select and enable inactive and `req_ready_o` low. After a write, `req_ready_o` is high again in the done cycle.
- R11: `req_done_o` is a single-cycle pulse. For a read, `req_rdata_o` holds the bus data sampled at the last bus edge, steered per R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_cb_i | input | 7 | Error-correction code for the write |
| req_done_o | output | 1 | Access complete pulse |
| req_err_o | output | 1 | Unmapped-address pulse |
| req_rdata_o | output | 32 | Read data |
| req_rcb_o | output | 8 | Check bits sampled on read |
| cfg_rom_ws_i | input | 4 | PROM wait states |
| cfg_ram_ws_i | input | 4 | SRAM wait states |
| cfg_rom_8bit_i | input | 1 | PROM is 8 bits wide |
| cfg_io_8bit_i | input | 1 | I/O area is 8 bits wide |
| cfg_rom_prot_i | input | 1 | PROM carries check bits |
| cfg_ram_prot_i | input | 1 | SRAM carries check bits |
| cfg_tb7_i | input | 1 | Test bit placed on check-bit pin 7 |
| mem_a_o | output | 23 | Bus address |
| mem_d_o | output | 32 | Bus data out |
| mem_d_oe_o | output | 1 | Bus data driver enable |
| mem_d_i | input | 32 | Bus data in |
| mem_cb_o | output | 8 | Check bits out |
| mem_cb_oe_o | output | 1 | Check-bit driver enable |
| mem_cb_i | input | 8 | Check bits in |
| rom_cs_no | output | 2 | PROM selects, lower/upper half |
| ram_cs_no | output | 4 | SRAM bank selects |
| ram_oe_no | output | 4 | SRAM bank output enables |
| mem_we_no | output | 4 | Byte write strobes, bit 0 = bits [31:24] |
| io_cs_no | output | 1 | I/O area select |
| io_oe_no | output | 1 | I/O output enable |
| io_rd_o | output | 1 | I/O read indicator |
| io_we_no | output | 1 | I/O write strobe |
| io_rdy_ni | input | 1 | I/O ready, active low |

## Verification
The bench uses the default parameters: four banks, four lanes, a 4-bit wait-state field and 23 address pins. It sweeps PROM and SRAM wait states from 0 to 2, with one access at the maximum of 15. The I/O ready delay follows the same values, so every latency formula is checked at several points. Each read and write goes to both PROM halves, all four SRAM banks and the I/O area. This is repeated under every combination of 8-bit width and protection. All sixteen address nibbles are tried, so every unmapped value goes through the error path with the address hold observed at the pins.

// File: rtl/emc_pkg.sv
package emc_pkg;
  typedef enum logic [1:0] {RG_NONE, RG_ROM, RG_RAM, RG_IO} region_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_IOEND, ST_TURN} state_e;
  localparam int CODE_W = 7;
endpackage

// File: rtl/emc_decode.sv
module emc_decode
  import emc_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic [3:0]        nib_i,
  input  logic [BANK_W-1:0] bank_bits_i,
  output region_e           region_o,
  output logic              rom_hi_o,
  output logic [BANK_W-1:0] bank_o
);
  always_comb begin
    unique case (nib_i)
      4'h0, 4'h1: region_o = RG_ROM;
      4'h2:       region_o = RG_IO;
      4'h4:       region_o = RG_RAM;
      default:    region_o = RG_NONE;
    endcase
  end
  assign rom_hi_o = nib_i[0];
  assign bank_o   = bank_bits_i;
endmodule

// File: rtl/emc_seq.sv
module emc_seq
  import emc_pkg::*;
#(
  parameter int WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            bad_i,
  input  logic            is_io_i,
  input  logic            is_read_i,
  input  logic [WS_W-1:0] ws_i,
  input  logic            io_rdy_ni,
  output logic            ready_o,
  output logic            active_o,
  output logic            complete_o,
  output logic            done_o,
  output logic            err_o
);
  state_e          state_q;
  logic [WS_W-1:0] cnt_q;
  logic            done_q, err_q;

  assign ready_o    = (state_q == ST_IDLE);
  assign active_o   = (state_q == ST_ACC) || (state_q == ST_IOEND);
  assign complete_o = ((state_q == ST_ACC) && !is_io_i && (cnt_q == '0))
                   || (state_q == ST_IOEND);
  assign done_o     = done_q;
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= complete_o;
      err_q  <= bad_i;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ACC;
          cnt_q   <= ws_i;
        end
        ST_ACC: begin
          if (is_io_i) begin
            if (!io_rdy_ni) state_q <= ST_IOEND;
          end else if (cnt_q == '0) begin
            state_q <= is_read_i ? ST_TURN : ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_IOEND: state_q <= is_read_i ? ST_TURN : ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_TURN_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_o && is_read_i) |=> !ready_o && !active_o); // R10
  AST_IO_WAITS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && is_io_i && !complete_o && io_rdy_ni) |=> !complete_o); // R5
  AST_ERR_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !active_o); // R1
endmodule

// File: rtl/emc_lanes.sv
module emc_lanes
  import emc_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int NLANE  = 4,
  parameter int BANK_W = $clog2(NBANK),
  parameter int DW     = 8 * NLANE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              write_i,
  input  region_e           region_i,
  input  logic              rom_hi_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              narrow_i,
  input  logic              prot_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [CODE_W-1:0] cb_i,
  input  logic              tb7_i,
  input  logic [DW-1:0]     mem_d_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     mem_d_o,
  output logic              mem_d_oe_o,
  output logic [7:0]        mem_cb_o,
  output logic              mem_cb_oe_o,
  output logic [1:0]        rom_cs_no,
  output logic [NBANK-1:0]  ram_cs_no,
  output logic [NBANK-1:0]  ram_oe_no,
  output logic [NLANE-1:0]  mem_we_no,
  output logic              io_cs_no,
  output logic              io_oe_no,
  output logic              io_rd_o,
  output logic              io_we_no
);
  logic act_rom, act_ram, act_io, mem_wr;

  assign act_rom = active_i && (region_i == RG_ROM);
  assign act_ram = active_i && (region_i == RG_RAM);
  assign act_io  = active_i && (region_i == RG_IO);
  assign mem_wr  = (act_rom || act_ram) && write_i;

  assign rom_cs_no = ~({rom_hi_i, !rom_hi_i} & {2{act_rom}});

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign ram_cs_no[b] = !(act_ram && (bank_i == BANK_W'(b)));
    assign ram_oe_no[b] = !(act_ram && !write_i && (bank_i == BANK_W'(b)));
  end

  // lane 0 is the most significant byte; narrow regions use lane 0 only
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int HI = DW - 1 - 8 * k;
    if (k == 0) begin : g_top
      assign mem_d_o[HI -: 8] = narrow_i ? wdata_i[7:0] : wdata_i[HI -: 8];
      assign mem_we_no[k]     = !mem_wr;
    end else begin : g_low
      assign mem_d_o[HI -: 8] = narrow_i ? 8'h00 : wdata_i[HI -: 8];
      assign mem_we_no[k]     = !(mem_wr && !narrow_i);
    end
  end

  assign rdata_o     = narrow_i ? {{(DW-8){1'b0}}, mem_d_i[DW-1 -: 8]} : mem_d_i;
  assign mem_d_oe_o  = active_i && write_i;
  assign mem_cb_o    = {tb7_i, cb_i};
  assign mem_cb_oe_o = mem_wr && prot_i;

  assign io_cs_no = !act_io;
  assign io_oe_no = !(act_io && !write_i);
  assign io_rd_o  = act_io && !write_i;
  assign io_we_no = !(act_io && write_i);

  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~rom_cs_no, ~ram_cs_no, ~io_cs_no})); // R1
  AST_CB_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cb_oe_o |-> mem_d_oe_o && io_cs_no); // R8
  AST_OE_NOT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&ram_oe_no) |-> (&mem_we_no)); // R3
endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import emc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int WS_W   = 4,
  parameter int NBANK  = 4,
  parameter int BANK_LSB = 20,
  localparam int BANK_W = $clog2(NBANK),
  localparam int NLANE  = 4,
  localparam int DW     = 8 * NLANE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [31:0]       req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [6:0]        req_cb_i,
  output logic              req_done_o,
  output logic              req_err_o,
  output logic [DW-1:0]     req_rdata_o,
  output logic [7:0]        req_rcb_o,
  input  logic [WS_W-1:0]   cfg_rom_ws_i,
  input  logic [WS_W-1:0]   cfg_ram_ws_i,
  input  logic              cfg_rom_8bit_i,
  input  logic              cfg_io_8bit_i,
  input  logic              cfg_rom_prot_i,
  input  logic              cfg_ram_prot_i,
  input  logic              cfg_tb7_i,
  output logic [ADDR_W-1:0] mem_a_o,
  output logic [DW-1:0]     mem_d_o,
  output logic              mem_d_oe_o,
  input  logic [DW-1:0]     mem_d_i,
  output logic [7:0]        mem_cb_o,
  output logic              mem_cb_oe_o,
  input  logic [7:0]        mem_cb_i,
  output logic [1:0]        rom_cs_no,
  output logic [NBANK-1:0]  ram_cs_no,
  output logic [NBANK-1:0]  ram_oe_no,
  output logic [NLANE-1:0]  mem_we_no,
  output logic              io_cs_no,
  output logic              io_oe_no,
  output logic              io_rd_o,
  output logic              io_we_no,
  input  logic              io_rdy_ni
);
  region_e           dec_region, region_q;
  logic              dec_rom_hi, rom_hi_q;
  logic [BANK_W-1:0] dec_bank, bank_q;
  logic              accept, start, bad;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q, rdata_q, lane_rdata;
  logic [6:0]        cb_q;
  logic [7:0]        rcb_q;
  logic              write_q, narrow_q, prot_q;
  logic              active, complete;
  logic [WS_W-1:0]   ws_sel;
  logic              unused_addr;

  assign unused_addr = ^req_addr_i[27:ADDR_W];

  emc_decode #(.BANK_W(BANK_W)) u_decode (
    .nib_i       (req_addr_i[31:28]),
    .bank_bits_i (req_addr_i[BANK_LSB +: BANK_W]),
    .region_o    (dec_region),
    .rom_hi_o    (dec_rom_hi),
    .bank_o      (dec_bank)
  );

  assign accept = req_valid_i && req_ready_o;
  assign start  = accept && (dec_region != RG_NONE);
  assign bad    = accept && (dec_region == RG_NONE);
  assign ws_sel = (dec_region == RG_ROM) ? cfg_rom_ws_i : cfg_ram_ws_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      cb_q     <= '0;
      write_q  <= 1'b0;
      region_q <= RG_NONE;
      rom_hi_q <= 1'b0;
      bank_q   <= '0;
      narrow_q <= 1'b0;
      prot_q   <= 1'b0;
      rdata_q  <= '0;
      rcb_q    <= '0;
    end else begin
      if (start) begin
        addr_q   <= req_addr_i[ADDR_W-1:0];
        wdata_q  <= req_wdata_i;
        cb_q     <= req_cb_i;
        write_q  <= req_write_i;
        region_q <= dec_region;
        rom_hi_q <= dec_rom_hi;
        bank_q   <= dec_bank;
        narrow_q <= (dec_region == RG_ROM && cfg_rom_8bit_i)
                 || (dec_region == RG_IO && cfg_io_8bit_i);
        prot_q   <= (dec_region == RG_ROM && cfg_rom_prot_i && !cfg_rom_8bit_i)
                 || (dec_region == RG_RAM && cfg_ram_prot_i);
      end
      if (complete && !write_q) begin
        rdata_q <= lane_rdata;
        rcb_q   <= mem_cb_i;
      end
    end
  end

  emc_seq #(.WS_W(WS_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .bad_i      (bad),
    .is_io_i    (region_q == RG_IO),
    .is_read_i  (!write_q),
    .ws_i       (ws_sel),
    .io_rdy_ni  (io_rdy_ni),
    .ready_o    (req_ready_o),
    .active_o   (active),
    .complete_o (complete),
    .done_o     (req_done_o),
    .err_o      (req_err_o)
  );

  emc_lanes #(.NBANK(NBANK), .NLANE(NLANE)) u_lanes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .write_i     (write_q),
    .region_i    (region_q),
    .rom_hi_i    (rom_hi_q),
    .bank_i      (bank_q),
    .narrow_i    (narrow_q),
    .prot_i      (prot_q),
    .wdata_i     (wdata_q),
    .cb_i        (cb_q),
    .tb7_i       (cfg_tb7_i),
    .mem_d_i     (mem_d_i),
    .rdata_o     (lane_rdata),
    .mem_d_o     (mem_d_o),
    .mem_d_oe_o  (mem_d_oe_o),
    .mem_cb_o    (mem_cb_o),
    .mem_cb_oe_o (mem_cb_oe_o),
    .rom_cs_no   (rom_cs_no),
    .ram_cs_no   (ram_cs_no),
    .ram_oe_no   (ram_oe_no),
    .mem_we_no   (mem_we_no),
    .io_cs_no    (io_cs_no),
    .io_oe_no    (io_oe_no),
    .io_rd_o     (io_rd_o),
    .io_we_no    (io_we_no)
  );

  assign mem_a_o     = addr_q;
  assign req_rdata_o = rdata_q;
  assign req_rcb_o   = rcb_q;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> $stable(mem_a_o)); // R9
  AST_DRV_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_d_oe_o |-> !io_rd_o && (&ram_oe_no)); // R6
  AST_ERR_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> !req_done_o); // R1
endmodule

// File: tb/ext_mem_ctrl_tb.sv
`timescale 1ns/1ps
module ext_mem_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic [6:0]  req_cb_i = '0;
  logic        req_ready_o, req_done_o, req_err_o;
  logic [31:0] req_rdata_o;
  logic [7:0]  req_rcb_o;
  logic [3:0]  cfg_rom_ws_i = '0, cfg_ram_ws_i = '0;
  logic        cfg_rom_8bit_i = 0, cfg_io_8bit_i = 0, cfg_rom_prot_i = 0, cfg_ram_prot_i = 0, cfg_tb7_i = 0;
  logic [22:0] mem_a_o;
  logic [31:0] mem_d_o, mem_d_i;
  logic        mem_d_oe_o, mem_cb_oe_o;
  logic [7:0]  mem_cb_o, mem_cb_i;
  logic [1:0]  rom_cs_no;
  logic [3:0]  ram_cs_no, ram_oe_no, mem_we_no;
  logic        io_cs_no, io_oe_no, io_rd_o, io_we_no;
  logic        io_rdy_ni = 1'b1;

  int checks = 0, errors = 0;
  logic [22:0] prev_a = '0;
  localparam logic [17:0] IDLE_SEL = {2'b11, 4'hF, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1};

  always #4 clk_i = ~clk_i;

  ext_mem_ctrl u_dut (.*);

  function automatic logic [31:0] dev_word(input logic [22:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'h96, {1'b0, a[22:16]} ^ 8'h5A, a[7:0] + 8'h11};
  endfunction
  assign mem_d_i  = dev_word(mem_a_o);
  assign mem_cb_i = mem_a_o[7:0] ^ 8'hC3;

  function automatic logic [17:0] sel_now();
    return {rom_cs_no, ram_cs_no, ram_oe_no, mem_we_no, io_cs_no, io_oe_no, io_rd_o, io_we_no};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [6:0] cb, input int iodly);
    logic [3:0] nib;
    bit rom, ram, io, narrow, prot;
    logic [1:0] bank;
    logic [17:0] exp_sel;
    logic [31:0] exp_d;
    int n, exp_n, bad_hold;
    nib = a[31:28];
    rom = (nib == 4'h0 || nib == 4'h1);
    ram = (nib == 4'h4);
    io  = (nib == 4'h2);
    bank = a[21:20];
    narrow = (rom && cfg_rom_8bit_i) || (io && cfg_io_8bit_i);
    prot = (rom && cfg_rom_prot_i && !cfg_rom_8bit_i) || (ram && cfg_ram_prot_i);
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R10 ready before request", req_ready_o, 1);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = wd; req_cb_i = cb;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n = 1;
    if (!(rom || ram || io)) begin
      chk(req_err_o == 1'b1, "R1 error pulse", req_err_o, 1);
      chk(sel_now() == IDLE_SEL && !mem_d_oe_o, "R1 no bus on error", sel_now(), IDLE_SEL);
      chk(mem_a_o == prev_a, "R9 address kept on error", mem_a_o, prev_a);
      @(negedge clk_i);
      chk(req_err_o == 1'b0 && req_done_o == 1'b0, "R1 error single cycle", req_err_o, 0);
      return;
    end
    exp_sel = IDLE_SEL;
    if (rom) exp_sel[17:16] = (nib == 4'h0) ? 2'b10 : 2'b01;
    if (ram) begin
      exp_sel[15:12] = ~(4'b1 << bank);
      if (!wr) exp_sel[11:8] = ~(4'b1 << bank);
    end
    if ((rom || ram) && wr) exp_sel[7:4] = narrow ? 4'b1110 : 4'b0000;
    if (io) begin
      exp_sel[3] = 1'b0;
      if (wr) exp_sel[0] = 1'b0; else begin exp_sel[2] = 1'b0; exp_sel[1] = 1'b1; end
    end
    exp_d = narrow ? {wd[7:0], 24'h0} : wd;
    chk(sel_now() == exp_sel, rom ? "R2 PROM select pattern" : ram ? "R3 SRAM bank pattern" : "R5 I/O pattern",
        sel_now(), exp_sel);
    chk(mem_a_o == a[22:0], "R9 address on pins", mem_a_o, a[22:0]);
    chk(mem_d_oe_o == wr, "R6 data driver only on write", mem_d_oe_o, wr);
    if (wr) chk(mem_d_o == exp_d, narrow ? "R7 narrow write lane" : "R6 write data", mem_d_o, exp_d);
    chk(mem_cb_oe_o == (wr && prot), "R8 check-bit driver", mem_cb_oe_o, wr && prot);
    if (wr && prot) chk(mem_cb_o == {cfg_tb7_i, cb}, "R8 check-bit value", mem_cb_o, {cfg_tb7_i, cb});
    exp_n = io ? iodly + 3 : (rom ? int'(cfg_rom_ws_i) : int'(cfg_ram_ws_i)) + 2;
    bad_hold = 0;
    io_rdy_ni = !(io && n > iodly);
    while (!req_done_o && n < 40) begin
      if (sel_now() != exp_sel) bad_hold++;
      @(negedge clk_i);
      n++;
      io_rdy_ni = !(io && n > iodly);
    end
    io_rdy_ni = 1'b1;
    chk(bad_hold == 0, "R4 selects held through access", bad_hold, 0);
    chk(n == exp_n, io ? "R5 I/O completion cycle" : "R4 wait-state latency", n, exp_n);
    chk(sel_now() == IDLE_SEL && !mem_d_oe_o, "R10 bus idle in done cycle", sel_now(), IDLE_SEL);
    chk(req_ready_o == wr, "R10 ready after access", req_ready_o, wr);
    chk(mem_a_o == a[22:0], "R9 address held after access", mem_a_o, a[22:0]);
    if (!wr) begin
      logic [31:0] w;
      w = dev_word(a[22:0]);
      if (narrow) w = {24'h0, w[31:24]};
      chk(req_rdata_o == w, narrow ? "R7 narrow read data" : "R11 read data", req_rdata_o, w);
      chk(req_rcb_o == (a[7:0] ^ 8'hC3), "R8 sampled check bits", req_rcb_o, a[7:0] ^ 8'hC3);
    end
    prev_a = a[22:0];
    @(negedge clk_i);
    chk(req_done_o == 1'b0, "R11 done single cycle", req_done_o, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !req_done_o && !req_err_o, "R10 reset ready", {req_ready_o, req_done_o, req_err_o}, 3'b100);
    chk(sel_now() == IDLE_SEL && !mem_d_oe_o && !mem_cb_oe_o, "R6 reset idle bus", sel_now(), IDLE_SEL);
    chk(mem_a_o == '0, "R9 reset address", mem_a_o, 0);
    for (int cfg = 0; cfg < 4; cfg++) begin
      cfg_rom_8bit_i = cfg[0]; cfg_io_8bit_i = cfg[0];
      cfg_rom_prot_i = cfg[1]; cfg_ram_prot_i = cfg[1];
      for (int ws = 0; ws < 3; ws++) begin
        cfg_rom_ws_i = 4'(ws); cfg_ram_ws_i = 4'(2 - ws); cfg_tb7_i = ws[0];
        for (int t = 0; t < 7; t++) begin
          for (int w = 0; w < 2; w++) begin
            logic [31:0] a;
            logic [31:0] off;
            off = 32'((t * 32'h1357 + ws * 32'h2468 + cfg * 32'h0411 + w * 4) & 32'h000F_FFFC);
            if (t == 0)      a = 32'h0000_0000 | off | 32'h0040_0000;
            else if (t == 1) a = 32'h1000_0000 | off;
            else if (t < 6)  a = 32'h4000_0000 | 32'((t - 2) << 20) | off;
            else             a = 32'h2000_0000 | off;
            access(w[0], a, 32'hA5C3_1E00 ^ (a * 7), 7'(a[8:2] ^ 7'h35), ws);
          end
        end
      end
    end
    cfg_rom_8bit_i = 0; cfg_rom_ws_i = 4'hF;
    access(1'b0, 32'h1012_3450, 32'h0, 7'h0, 0);
    for (int nb = 0; nb < 16; nb++)
      access(1'b0, {4'(nb), 28'h07A_BCD4}, 32'h0, 7'h0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule